// File: doc/BRIEF.md
# Sticky Event Flag Register with Write-One Clear

This block holds eight sticky status flags for a serial bus controller. A hardware event pulse sets a flag, and the flag stays set until software writes a 1 to its bit position. A clear request is honoured only once the condition that raised the flag has gone away. While that condition is still active, the write-one clear is refused and the flag stays set.

Each flag has a mask bit in a separate enable register, which the block receives on an input port. For every flag the block forms a registered interrupt request, equal to the flag ANDed with its enable. It also forms a registered request that is the OR of all eight. The surrounding logic supplies the per-flag events and conditions: error counters, a wake-up detector and receive-buffer status. Software reads the flags directly from `flags_o`, and reading has no side effect.

Top module: `irq_flag_reg`

## Requirements
- R1: The bit layout from bit 7 down to bit 0 is: bus wake-up, receive warning, transmit warning, receive error-passive, transmit error-passive, bus-off, receiver overrun, receive buffer full. An event on `set_i[k]` lands in `flags_o[k]`.
- R2: A 1 on `set_i[k]` at a rising clock edge makes `flags_o[k]` read 1 after that edge. The flag stays 1 after the event pulse ends.
- R3: With `wr_en` high, a 1 in `wr_data[k]` clears flag k at that edge when `cond_i[k]` is low. A 0 in `wr_data[k]` leaves flag k unchanged.
- R4: A write-one clear to flag k is refused while `cond_i[k]` is high, and the flag remains 1.
- R5: If an event and an accepted clear for the same bit arrive at the same edge, the flag ends up 1.
- R6: Bit 7 (wake-up) is set only when `set_i[7]` is high while `sleep_i` is high. Otherwise `set_i[7]` has no effect.
- R7: Hard reset (`rst_n` low, asynchronous) clears all flags and all interrupt outputs at once. Soft reset (`soft_rst` high at an edge) clears them at that edge and overrides any event.
- R8: `irq_o[k]` equals `flags_o[k] & irq_en_i[k]` as sampled at the previous edge. This gives one register stage.
- R9: `irq_any_o` equals the OR over all k of `flags_o[k] & irq_en_i[k]` as sampled at the previous edge.
- R10: With no event, no write and no reset, every flag holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Hard reset, asynchronous, active low |
| soft_rst | input | 1 | Soft reset, synchronous, active high |
| sleep_i | input | 1 | Controller is in sleep mode; qualifies the wake-up event |
| set_i | input | 8 | Per-flag event pulses |
| cond_i | input | 8 | Per-flag cause still active; blocks clearing |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Write data; 1 requests a clear |
| irq_en_i | input | 8 | Per-flag interrupt enable mask |
| flags_o | output | 8 | Current flag values (read data) |
| irq_o | output | 8 | Registered per-flag interrupt requests |
| irq_any_o | output | 1 | Registered OR of all unmasked flags |

## Verification
Flag changes are due one edge after the inputs that cause them. The interrupt outputs follow one edge after the flags, so they lag an event by two edges. Hard reset is the exception: it clears every output without waiting for an edge. The bench drives inputs on the falling clock edge. A behavioural model in the bench advances on the rising edge, and all outputs are compared against it on the next falling edge, so every result is sampled half a cycle after the edge that produces it. Directed checks before and after the asynchronous reset probe the outputs a few nanoseconds apart within a single clock phase.

// File: rtl/irq_flag_reg.sv
module irq_flag_reg #(
  parameter int NFLAG    = 8,
  parameter int WAKE_BIT = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_rst,
  input  logic             sleep_i,
  input  logic [NFLAG-1:0] set_i,
  input  logic [NFLAG-1:0] cond_i,
  input  logic             wr_en,
  input  logic [NFLAG-1:0] wr_data,
  input  logic [NFLAG-1:0] irq_en_i,
  output logic [NFLAG-1:0] flags_o,
  output logic [NFLAG-1:0] irq_o,
  output logic             irq_any_o
);

  logic [NFLAG-1:0] flags_q, set_eff, clr_ok, flags_d, pend;
  logic [NFLAG-1:0] irq_q;
  logic             any_q;

  always_comb begin
    set_eff = set_i;
    set_eff[WAKE_BIT] = set_i[WAKE_BIT] & sleep_i;
  end

  assign clr_ok  = wr_en ? (wr_data & ~cond_i) : '0;
  assign flags_d = set_eff | (flags_q & ~clr_ok);
  assign pend    = flags_q & irq_en_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
      irq_q   <= '0;
      any_q   <= 1'b0;
    end else if (soft_rst) begin
      flags_q <= '0;
      irq_q   <= '0;
      any_q   <= 1'b0;
    end else begin
      flags_q <= flags_d;
      irq_q   <= pend;
      any_q   <= |pend;
    end
  end

  assign flags_o   = flags_q;
  assign irq_o     = irq_q;
  assign irq_any_o = any_q;

  // R2
  event_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !soft_rst |=> ((flags_o & $past(set_eff)) == $past(set_eff)));

  // R4
  clear_refused_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !soft_rst |=> ((flags_o & $past(flags_o & cond_i)) == $past(flags_o & cond_i)));

  // R3
  clear_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !soft_rst |=> ((flags_o & $past(clr_ok & ~set_eff)) == '0));

  // R6
  wake_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep_i && !flags_o[WAKE_BIT]) |=> !flags_o[WAKE_BIT]);

  // R7
  soft_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (flags_o == '0 && irq_o == '0 && !irq_any_o));

  // R8
  irq_stage_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !soft_rst |=> (irq_o == $past(flags_o & irq_en_i)));

  // R9
  irq_any_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !soft_rst |=> (irq_any_o == (|$past(flags_o & irq_en_i))));

  // R10
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!soft_rst && !wr_en && set_i == '0) |=> $stable(flags_o));

endmodule

// File: tb/irq_flag_reg_bench.sv
module irq_flag_reg_bench;
  logic       clk = 1'b0;
  logic       rst_n, soft_rst, sleep_i, wr_en;
  logic [7:0] set_i, cond_i, wr_data, irq_en_i;
  logic [7:0] flags_o, irq_o;
  logic       irq_any_o;

  logic [7:0] m_flags, m_irq;
  logic       m_any;
  int         n_vec = 0, n_bad = 0;
  bit         done = 0;

  always #10 clk = ~clk;

  irq_flag_reg u_irq_flag_reg (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .sleep_i(sleep_i),
    .set_i(set_i), .cond_i(cond_i), .wr_en(wr_en), .wr_data(wr_data),
    .irq_en_i(irq_en_i), .flags_o(flags_o), .irq_o(irq_o), .irq_any_o(irq_any_o)
  );

  // reference model
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n || soft_rst) begin
      m_flags <= 8'h00; m_irq <= 8'h00; m_any <= 1'b0;
    end else begin
      logic [7:0] nf;
      for (int b = 0; b < 8; b++) begin
        bit s, c;
        s = set_i[b] && (b != 7 || sleep_i);
        c = wr_en && wr_data[b] && !cond_i[b];
        nf[b] = s ? 1'b1 : (c ? 1'b0 : m_flags[b]);
      end
      m_irq   <= m_flags & irq_en_i;
      m_any   <= (m_flags & irq_en_i) != 8'h00;
      m_flags <= nf;
    end
  end

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n === 1'b1 && !done) begin
    chk("R10 model flags", flags_o, m_flags);
    chk("R8 model irq", irq_o, m_irq);
    chk("R9 model any", {7'b0, irq_any_o}, {7'b0, m_any});
  end

  task automatic tick(); @(posedge clk); @(negedge clk); endtask

  task automatic idle();
    set_i = 0; wr_en = 0; wr_data = 0; soft_rst = 0;
  endtask

  initial begin
    #(200000 * 20);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] acc;
    rst_n = 0; soft_rst = 0; sleep_i = 1; set_i = 0; cond_i = 0;
    wr_en = 0; wr_data = 0; irq_en_i = 0;
    tick(); tick();
    chk("R7 reset flags", flags_o, 8'h00);
    chk("R7 reset irq", irq_o, 8'h00);
    rst_n = 1;
    tick();

    // R1 and R2: one flag per event bit, accumulating
    acc = 0;
    for (int b = 0; b < 8; b++) begin
      set_i = 8'(1 << b);
      tick();
      set_i = 0;
      acc[b] = 1'b1;
      chk("R1 bit position", flags_o, acc);
    end
    tick();
    chk("R2 sticky", flags_o, 8'hFF);

    // R8, R9
    irq_en_i = 8'hA5;
    tick();
    chk("R8 irq masked", irq_o, 8'hA5);
    chk("R9 any", {7'b0, irq_any_o}, 8'h01);

    // R3
    wr_en = 1; wr_data = 8'h0F;
    tick();
    chk("R3 clear", flags_o, 8'hF0);
    wr_data = 8'h00;
    tick();
    chk("R3 zero no effect", flags_o, 8'hF0);

    // R4
    cond_i = 8'h30; wr_data = 8'hF0;
    tick();
    chk("R4 refused", flags_o, 8'h30);
    cond_i = 8'h00;
    tick();
    chk("R4 cause gone", flags_o, 8'h00);
    wr_en = 0;
    tick();
    chk("R8 irq cleared", irq_o, 8'h00);

    // R5
    set_i = 8'h02; wr_en = 1; wr_data = 8'h02;
    tick();
    idle();
    chk("R5 set wins", flags_o, 8'h02);

    // R6
    sleep_i = 0; set_i = 8'h80;
    tick();
    idle();
    chk("R6 awake ignores", flags_o, 8'h02);
    sleep_i = 1; set_i = 8'h80;
    tick();
    idle();
    chk("R6 sleep sets", flags_o, 8'h82);

    // R10
    repeat (5) tick();
    chk("R10 hold", flags_o, 8'h82);

    // R7 soft reset beats events
    soft_rst = 1; set_i = 8'hFF;
    tick();
    idle();
    chk("R7 soft flags", flags_o, 8'h00);
    chk("R7 soft irq", irq_o, 8'h00);

    // R7 asynchronous hard reset
    set_i = 8'h3C; irq_en_i = 8'hFF;
    tick(); idle(); tick();
    chk("R7 pre hard", irq_o, 8'h3C);
    #3 rst_n = 0;
    #1;
    chk("R7 async flags", flags_o, 8'h00);
    chk("R7 async irq", irq_o, 8'h00);
    @(negedge clk);
    rst_n = 1;
    tick();

    // random traffic, compared every clock against the model
    for (int i = 0; i < 400; i++) begin
      set_i    = $urandom & $urandom;
      cond_i   = $urandom;
      wr_en    = $urandom_range(0, 1);
      wr_data  = $urandom;
      sleep_i  = $urandom_range(0, 1);
      irq_en_i = $urandom;
      soft_rst = ($urandom_range(0, 31) == 0);
      tick();
    end
    idle();
    tick();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule